// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation cache after a miss. It takes a 32-bit virtual address and walks a two-level page table in memory, starting from a root pointer. It issues one word read for the first-level entry. If that entry is usable, it issues a second read for the leaf entry in the table that the first entry points to. A usable leaf produces a one-cycle refill that carries the virtual page number, the physical page number and three permission bits. If either entry is unusable, the walk is abandoned. A one-cycle page-fault pulse then names the failing level and the virtual address.

The walker only reads memory. Its read port uses a request/ready handshake and a separate response-valid strobe, and one read is outstanding at a time. The walker serves one walk at a time. While a walk is in progress, it accepts no new miss.

Each page-table entry is one 32-bit word:

| Bits | Meaning |
|------|---------|
| 0 | entry exists |
| 1 | page is resident in memory |
| 2 | read permission |
| 3 | write permission |
| 4 | dirty |
| 11:5 | ignored |
| 31:12 | page number |

Top module: `ptw_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `miss_ready` is 1 and `mem_req_valid`, `refill_valid` and `fault_valid` are 0.
- R2: A miss is accepted only when `miss_ready` is 1 and `miss_valid` is 1. `miss_ready` then falls for the whole walk. A `miss_valid` pulse or a changed `miss_va` during a walk is ignored, and the walk completes for the address accepted first.
- R3: The first read targets `root + 4*va[31:22]`. `root_base` is sampled in the accepting cycle, and later changes to it do not affect the walk.
- R4: The second read targets `{L1.page_number, 12'h000} + 4*va[21:12]`.
- R5: A read request is held with an unchanged address until the cycle in which `mem_req_ready` is 1. At most one read is outstanding.
- R6: If the first-level entry lacks bit 0 or bit 1, no second read is made. A fault is reported with `fault_level`=0 and `fault_va` equal to the accepted address.
- R7: If the leaf entry lacks bit 0 or bit 1, a fault is reported with `fault_level`=1 and no refill.
- R8: A usable leaf produces one `refill_valid` cycle. In that cycle `refill_vpn`=va[31:12], `refill_ppn`=leaf[31:12], and `refill_perm` = {leaf bit 4 (dirty), leaf bit 3 (write), leaf bit 2 (read)} in positions [2:0].
- R9: Every walk ends in exactly one one-cycle pulse, either refill or fault, never both. After that pulse `miss_ready` is 1 again.
- R10: `mem_rsp_valid` is ignored while no read is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| miss_valid | input | 1 | miss request |
| miss_va | input | 32 | virtual address of the miss |
| miss_ready | output | 1 | walker idle, miss accepted |
| root_base | input | 32 | physical byte address of the first-level table |
| mem_req_valid | output | 1 | read request |
| mem_req_addr | output | 32 | byte address of the entry to read |
| mem_req_ready | input | 1 | memory takes the request |
| mem_rsp_valid | input | 1 | read data valid |
| mem_rsp_data | input | 32 | entry word read |
| refill_valid | output | 1 | refill pulse |
| refill_vpn | output | 20 | virtual page number refilled |
| refill_ppn | output | 20 | physical page number |
| refill_perm | output | 3 | {dirty, write, read} |
| fault_valid | output | 1 | page fault pulse |
| fault_level | output | 1 | 0: first level failed, 1: leaf failed |
| fault_va | output | 32 | faulting virtual address |

## Verification
The bench targets each usability case. An entry that is resident but not marked existing must still fault, so a walker that checks only one of the two bits would refill wrongly. A first-level fault must suppress the second read, and a walker that ignores this would issue a stray request to an arbitrary address. The indices 0x3FF at both levels and a root change during a walk expose a wrong shift or a live root. Stalled requests, stray response strobes outside a read and miss pulses during a walk expose a walker that drops its held address, consumes a response it never asked for, or restarts.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   // entry flag positions, decoded by the walker
   localparam int PTE_EXIST_BIT = 0;
   localparam int PTE_RESID_BIT = 1;
   localparam int PTE_RD_BIT    = 2;
   localparam int PTE_WR_BIT    = 3;
   localparam int PTE_DIRTY_BIT = 4;
   localparam int PERM_W        = 3;

   typedef enum logic [2:0] {
      WALK_IDLE   = 3'd0,
      WALK_L1_REQ = 3'd1,
      WALK_L1_WT  = 3'd2,
      WALK_L2_REQ = 3'd3,
      WALK_L2_WT  = 3'd4,
      WALK_DONE   = 3'd5,
      WALK_FAULT  = 3'd6
   } walk_state_e;

   typedef struct packed {
      logic dirty;
      logic write;
      logic read;
   } walk_perm_t;

endpackage

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
   import ptw_pkg::*;
#(
   parameter int PTE_W = 32,
   parameter int OFS_W = 12,
   localparam int PN_W = PTE_W - OFS_W
) (
   input  logic [PTE_W-1:0] pte,
   output logic             usable,
   output logic [PN_W-1:0]  page_num,
   output walk_perm_t       perm
);

   logic unused_flags;

   if (OFS_W <= PTE_DIRTY_BIT) begin : g_bad_ofs
      $error("ptw_pte_check: flag bits must lie below the page number");
   end

   assign usable        = pte[PTE_EXIST_BIT] & pte[PTE_RESID_BIT];
   assign page_num      = pte[PTE_W-1:OFS_W];
   assign perm.read     = pte[PTE_RD_BIT];
   assign perm.write    = pte[PTE_WR_BIT];
   assign perm.dirty    = pte[PTE_DIRTY_BIT];
   assign unused_flags  = ^pte[OFS_W-1:PTE_DIRTY_BIT+1];

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int PA_W       = 32,
   parameter int L1_IDX_W   = 10,
   parameter int L2_IDX_W   = 10,
   parameter int PN_W       = 20,
   parameter int OFS_W      = 12,
   parameter int PTE_BYTES  = 4,
   parameter bit LATCH_ROOT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                capture,
   input  logic [PA_W-1:0]     root_base,
   input  logic [L1_IDX_W-1:0] l1_idx,
   input  logic [L2_IDX_W-1:0] l2_idx,
   input  logic [PN_W-1:0]     l1_page,
   input  logic                use_l2,
   output logic [PA_W-1:0]     addr
);

   localparam int SH     = $clog2(PTE_BYTES);
   localparam int PAD1   = PA_W - L1_IDX_W - SH;
   localparam int PAD2   = PA_W - L2_IDX_W - SH;

   logic [PA_W-1:0] root_eff;
   logic [PA_W-1:0] l1_addr;
   logic [PA_W-1:0] l2_addr;

   if (PA_W != PN_W + OFS_W) begin : g_bad_pa
      $error("ptw_addr_gen: page number plus offset must fill the address");
   end
   if ((1 << SH) != PTE_BYTES) begin : g_bad_pte
      $error("ptw_addr_gen: entry size must be a power of two");
   end
   if (PAD1 < 0 || PAD2 < 0) begin : g_bad_idx
      $error("ptw_addr_gen: index too wide for the address");
   end

   if (LATCH_ROOT) begin : g_root_reg
      logic [PA_W-1:0] root_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       root_q <= '0;
         else if (capture) root_q <= root_base;
      end
      assign root_eff = root_q;
   end else begin : g_root_live
      logic unused_cap;
      assign unused_cap = capture;
      assign root_eff   = root_base;
   end

   assign l1_addr = root_eff + {{PAD1{1'b0}}, l1_idx, {SH{1'b0}}};
   assign l2_addr = {l1_page, {OFS_W{1'b0}}} + {{PAD2{1'b0}}, l2_idx, {SH{1'b0}}};
   assign addr    = use_l2 ? l2_addr : l1_addr;

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
   import ptw_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        miss_valid,
   input  logic        req_ready,
   input  logic        rsp_valid,
   input  logic        pte_usable,
   output walk_state_e state,
   output logic        accept,
   output logic        take_l1,
   output logic        take_l2,
   output logic        fail_l1,
   output logic        fail_l2
);

   walk_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WALK_IDLE:   if (miss_valid) state_d = WALK_L1_REQ;
         WALK_L1_REQ: if (req_ready)  state_d = WALK_L1_WT;
         WALK_L1_WT:  if (rsp_valid)  state_d = pte_usable ? WALK_L2_REQ : WALK_FAULT;
         WALK_L2_REQ: if (req_ready)  state_d = WALK_L2_WT;
         WALK_L2_WT:  if (rsp_valid)  state_d = pte_usable ? WALK_DONE : WALK_FAULT;
         WALK_DONE:   state_d = WALK_IDLE;
         WALK_FAULT:  state_d = WALK_IDLE;
         default:     state_d = WALK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= WALK_IDLE;
      else        state_q <= state_d;
   end

   assign state   = state_q;
   assign accept  = (state_q == WALK_IDLE)  & miss_valid;
   assign take_l1 = (state_q == WALK_L1_WT) & rsp_valid &  pte_usable;
   assign fail_l1 = (state_q == WALK_L1_WT) & rsp_valid & ~pte_usable;
   assign take_l2 = (state_q == WALK_L2_WT) & rsp_valid &  pte_usable;
   assign fail_l2 = (state_q == WALK_L2_WT) & rsp_valid & ~pte_usable;

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PA_W       = 32,
   parameter int PTE_W      = 32,
   parameter int L1_IDX_W   = 10,
   parameter int L2_IDX_W   = 10,
   parameter int OFS_W      = 12,
   parameter bit LATCH_ROOT = 1'b1,
   localparam int PN_W      = PTE_W - OFS_W,
   localparam int VPN_W     = L1_IDX_W + L2_IDX_W,
   localparam int PTE_BYTES = PTE_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [VA_W-1:0]   miss_va,
   output logic              miss_ready,
   input  logic [PA_W-1:0]   root_base,
   output logic              mem_req_valid,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_req_ready,
   input  logic              mem_rsp_valid,
   input  logic [PTE_W-1:0]  mem_rsp_data,
   output logic              refill_valid,
   output logic [VPN_W-1:0]  refill_vpn,
   output logic [PN_W-1:0]   refill_ppn,
   output logic [PERM_W-1:0] refill_perm,
   output logic              fault_valid,
   output logic              fault_level,
   output logic [VA_W-1:0]   fault_va
);

   localparam int L1_LSB = OFS_W + L2_IDX_W;

   if (VA_W != VPN_W + OFS_W) begin : g_bad_va
      $error("ptw_walker: index and offset widths must fill the virtual address");
   end
   if (PTE_W % 8 != 0) begin : g_bad_pte_w
      $error("ptw_walker: entry width must be whole bytes");
   end

   walk_state_e state;
   logic        accept, take_l1, take_l2, fail_l1, fail_l2;
   logic        usable;
   logic [PN_W-1:0] rsp_pn;
   walk_perm_t  rsp_perm;

   logic [VA_W-1:0] va_q;
   logic [PN_W-1:0] l1_pn_q;
   logic [PN_W-1:0] leaf_pn_q;
   walk_perm_t      leaf_perm_q;
   logic            lvl_q;

   ptw_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss_valid (miss_valid),
      .req_ready  (mem_req_ready),
      .rsp_valid  (mem_rsp_valid),
      .pte_usable (usable),
      .state      (state),
      .accept     (accept),
      .take_l1    (take_l1),
      .take_l2    (take_l2),
      .fail_l1    (fail_l1),
      .fail_l2    (fail_l2)
   );

   ptw_pte_check #(
      .PTE_W (PTE_W),
      .OFS_W (OFS_W)
   ) u_pte (
      .pte      (mem_rsp_data),
      .usable   (usable),
      .page_num (rsp_pn),
      .perm     (rsp_perm)
   );

   ptw_addr_gen #(
      .PA_W       (PA_W),
      .L1_IDX_W   (L1_IDX_W),
      .L2_IDX_W   (L2_IDX_W),
      .PN_W       (PN_W),
      .OFS_W      (OFS_W),
      .PTE_BYTES  (PTE_BYTES),
      .LATCH_ROOT (LATCH_ROOT)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (accept),
      .root_base (root_base),
      .l1_idx    (va_q[VA_W-1:L1_LSB]),
      .l2_idx    (va_q[L1_LSB-1:OFS_W]),
      .l1_page   (l1_pn_q),
      .use_l2    (state == WALK_L2_REQ),
      .addr      (mem_req_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q        <= '0;
         l1_pn_q     <= '0;
         leaf_pn_q   <= '0;
         leaf_perm_q <= '0;
         lvl_q       <= 1'b0;
      end else begin
         if (accept)  va_q    <= miss_va;
         if (take_l1) l1_pn_q <= rsp_pn;
         if (take_l2) begin
            leaf_pn_q   <= rsp_pn;
            leaf_perm_q <= rsp_perm;
         end
         if (fail_l1)      lvl_q <= 1'b0;
         else if (fail_l2) lvl_q <= 1'b1;
      end
   end

   assign miss_ready    = (state == WALK_IDLE);
   assign mem_req_valid = (state == WALK_L1_REQ) | (state == WALK_L2_REQ);
   assign refill_valid  = (state == WALK_DONE);
   assign refill_vpn    = va_q[VA_W-1:OFS_W];
   assign refill_ppn    = leaf_pn_q;
   assign refill_perm   = leaf_perm_q;
   assign fault_valid   = (state == WALK_FAULT);
   assign fault_level   = lvl_q;
   assign fault_va      = va_q;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
   parameter int VA_W  = 32,
   parameter int PA_W  = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            miss_valid,
   input logic            miss_ready,
   input logic            mem_req_valid,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            mem_req_ready,
   input logic            refill_valid,
   input logic            fault_valid,
   input logic [VA_W-1:0] fault_va
);

   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      miss_ready && miss_valid |=> !miss_ready);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      miss_ready |-> !mem_req_valid && !refill_valid && !fault_valid);

   assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(refill_valid && fault_valid));

   assert_refill_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      refill_valid |=> !refill_valid && miss_ready);

   assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |=> !fault_valid && miss_ready);

   assert_fault_va_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> $stable(fault_va));

endmodule

bind ptw_walker ptw_walker_chk #(
   .VA_W (VA_W),
   .PA_W (PA_W)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .miss_valid    (miss_valid),
   .miss_ready    (miss_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_addr  (mem_req_addr),
   .mem_req_ready (mem_req_ready),
   .refill_valid  (refill_valid),
   .fault_valid   (fault_valid),
   .fault_va      (fault_va)
);

// File: tb/test_ptw_walker.sv
module test_ptw_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_valid = 1'b0;
   logic [31:0] miss_va = '0;
   logic        miss_ready;
   logic [31:0] root_base = '0;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_req_ready = 1'b0;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        refill_valid;
   logic [19:0] refill_vpn;
   logic [19:0] refill_ppn;
   logic [2:0]  refill_perm;
   logic        fault_valid;
   logic        fault_level;
   logic [31:0] fault_va;

   always #2 clk = ~clk;

   ptw_walker i_ptw_walker (.*);

   int n_tests = 0;
   int n_fail  = 0;
   int n_refill = 0, n_f1 = 0, n_f2 = 0;
   int cyc = 0;
   bit stall_en = 0, spur_en = 0;
   int pend_cnt = -1;
   logic [31:0] pend_addr;
   logic [31:0] mem [logic [31:0]];

   // reference model state
   int          m_ph = 0;
   logic [31:0] m_va, m_root, m_leaf;
   logic [19:0] m_ppn1;
   logic        m_lvl;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   function automatic logic [31:0] mkva(input int i1, input int i2, input int off);
      return {i1[9:0], i2[9:0], off[11:0]};
   endfunction

   // behavioural model: phase 0 idle,1 first read,2 wait,3 second read,4 wait,5 refill,6 fault
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_ph <= 0;
      else begin
         case (m_ph)
            0: if (miss_valid) begin m_va <= miss_va; m_root <= root_base; m_ph <= 1; end
            1: if (mem_req_ready) m_ph <= 2;
            2: if (mem_rsp_valid) begin
                  if (mem_rsp_data[0] && mem_rsp_data[1]) begin m_ppn1 <= mem_rsp_data[31:12]; m_ph <= 3; end
                  else begin m_lvl <= 1'b0; m_ph <= 6; end
               end
            3: if (mem_req_ready) m_ph <= 4;
            4: if (mem_rsp_valid) begin
                  if (mem_rsp_data[0] && mem_rsp_data[1]) begin m_leaf <= mem_rsp_data; m_ph <= 5; end
                  else begin m_lvl <= 1'b1; m_ph <= 6; end
               end
            default: m_ph <= 0;
         endcase
      end
   end

   // memory responder, driven away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         mem_rsp_valid = 1'b0;
         mem_rsp_data  = 32'hDEAD_BEEF;
         if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = rd(pend_addr);
               pend_cnt = -1;
            end
         end else if (spur_en && (cyc % 4 == 0)) begin
            mem_rsp_valid = 1'b1;       // R10 stray strobe
            mem_rsp_data  = 32'h0002_0003;
         end
         mem_req_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
         if (mem_req_valid && mem_req_ready && pend_cnt < 0) begin
            pend_cnt  = 2;
            pend_addr = mem_req_addr;
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         logic [31:0] e_addr;
         chk(miss_ready == (m_ph == 0), "R2 miss_ready", miss_ready, m_ph == 0);
         chk(mem_req_valid == (m_ph == 1 || m_ph == 3), "R5 mem_req_valid", mem_req_valid, m_ph == 1 || m_ph == 3);
         if (m_ph == 1) begin
            e_addr = m_root + 32'(m_va[31:22]) * 4;
            chk(mem_req_addr == e_addr, "R3 first-level address", mem_req_addr, e_addr);
         end
         if (m_ph == 3) begin
            e_addr = {m_ppn1, 12'h000} + 32'(m_va[21:12]) * 4;
            chk(mem_req_addr == e_addr, "R4 leaf address", mem_req_addr, e_addr);
         end
         chk(refill_valid == (m_ph == 5), "R8 refill_valid", refill_valid, m_ph == 5);
         if (m_ph == 5) begin
            n_refill++;
            chk(refill_vpn == m_va[31:12], "R8 refill_vpn", refill_vpn, m_va[31:12]);
            chk(refill_ppn == m_leaf[31:12], "R8 refill_ppn", refill_ppn, m_leaf[31:12]);
            chk(refill_perm == {m_leaf[4], m_leaf[3], m_leaf[2]}, "R8 refill_perm", refill_perm, {m_leaf[4], m_leaf[3], m_leaf[2]});
         end
         chk(fault_valid == (m_ph == 6), "R6 fault_valid", fault_valid, m_ph == 6);
         if (m_ph == 6) begin
            if (m_lvl) n_f2++; else n_f1++;
            chk(fault_level == m_lvl, m_lvl ? "R7 fault_level" : "R6 fault_level", fault_level, m_lvl);
            chk(fault_va == m_va, "R6 fault_va", fault_va, m_va);
         end
         chk(!(refill_valid && fault_valid), "R9 single outcome", {refill_valid, fault_valid}, 0);
      end
   end

   task automatic walk(input logic [31:0] va, input bit noise, input bit root_move);
      do @(negedge clk); while (m_ph != 0);
      miss_valid = 1'b1;
      miss_va    = va;
      @(negedge clk);
      if (noise) miss_va = va ^ 32'hFFC0_0000;   // R2 stray miss during walk
      else miss_valid = 1'b0;
      if (root_move) root_base = 32'h0077_0000; // R3 root moves after accept
      repeat (3) @(negedge clk);
      miss_valid = 1'b0;
      do @(negedge clk); while (m_ph != 0);
      root_base = 32'h0001_0000;
   endtask

   initial begin
      root_base = 32'h0001_0000;
      mem[32'h0001_000C] = {20'h00020, 12'h003};
      mem[32'h0001_0010] = {20'h00030, 12'h001};  // exists, not resident
      mem[32'h0001_001C] = {20'h00050, 12'h002};  // resident, not existing
      mem[32'h0001_0FFC] = {20'h00040, 12'h003};
      mem[32'h0002_0014] = {20'hABCDE, 12'h01F};
      mem[32'h0002_0018] = {20'h11111, 12'h005};  // leaf not resident
      mem[32'h0004_0FFC] = {20'h55555, 12'h007};
      repeat (3) begin
         @(negedge clk);
         chk(miss_ready && !mem_req_valid && !refill_valid && !fault_valid, "R1 reset outputs",
             {miss_ready, mem_req_valid, refill_valid, fault_valid}, 4'b1000);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk(miss_ready && !mem_req_valid, "R1 idle after reset", {miss_ready, mem_req_valid}, 2'b10);

      walk(mkva(3, 5, 12'h123), 0, 0);      // R8 full success
      walk(mkva(4, 5, 0), 0, 0);            // R6 not resident
      walk(mkva(7, 0, 0), 0, 0);            // R6 resident but not existing
      walk(mkva(9, 2, 0), 0, 0);            // R6 unmapped
      walk(mkva(3, 6, 0), 0, 0);            // R7 leaf fault
      walk(mkva(1023, 1023, 12'hFFF), 0, 0);// R4 maximum indices
      stall_en = 1; spur_en = 1;
      walk(mkva(3, 5, 0), 1, 1);            // R5 R10 R2 R3 under stalls
      walk(mkva(3, 6, 12'h7), 1, 0);        // R7 under stalls
      walk(mkva(4, 0, 0), 0, 1);            // R6 under stalls
      spur_en = 0; stall_en = 0;
      repeat (4) @(negedge clk);

      chk(n_refill == 3, "R8 refill count", n_refill, 3);
      chk(n_f1 == 4, "R6 first-level fault count", n_f1, 4);
      chk(n_f2 == 2, "R7 leaf fault count", n_f2, 2);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog: walk never returned idle act=%0d exp=0", m_ph);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule